// File: doc/BRIEF.md
# Bit-level I2C master engine

This block is a single-master I2C engine that works at the level of individual bus primitives. A sequencer gives it one command at a time: start, stop, write one bit, read one bit, write a byte or read a byte. The engine drives each line only by pulling it low, and otherwise lets it float. It watches the wired-AND value of each line on a separate input. When the command is finished, or has failed, it returns a single result word.

Whenever the engine has to take SCL high, it releases the line and checks SCL in fixed polling steps. A slave can therefore stretch the clock. If SCL has not been seen high when the step budget runs out, the command fails. After a failure the lines stay exactly as they were, so the sequencer can decide to send a stop. The start command adapts to the bus. If both lines already read high, it goes straight to the start edge. Otherwise it first brings SCL low, releases SDA and raises SCL again, which gives a repeated start. All timing comes from nanosecond parameters and the clock frequency in MHz, with each value rounded up to whole cycles. The poll budget is the total timeout divided by the rise/fall interval.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both line drives are released, cmdReady is 1 and rspValid is 0.
- R2: Opcode 0 (start) with both lines high pulls SDA low while SCL stays high, then pulls SCL low. It reports rspOk=1 and leaves both lines driven low.
- R3: Opcode 0 with either line low first drives SCL low and releases SDA, then raises SCL. It then makes a start edge (SDA falls while SCL is high) and reports rspOk=1.
- R4: If SCL still reads low after the full poll budget (timeout divided by the rise/fall interval), the command ends with rspOk=0 and SCL left released.
- R5: A slave that holds SCL low for less than the poll budget only delays the command. The command still reports rspOk=1.
- R6: Opcode 1 (stop) drives both lines low, then releases SCL, then releases SDA, so that SDA rises while SCL is high. It reports rspOk=1 and leaves both lines released.
- R7: Opcode 4 (write byte) presents cmdData MSB first, one bit per SCL high phase. It then releases SDA for a ninth acknowledge bit. rspOk is the inverse of the sampled acknowledge bit (1 is NACK) and rspData is {7'b0, acknowledge bit}.
- R8: Opcode 5 (read byte) samples 8 bits MSB first into rspData, then releases SDA for the ninth bit (NACK). It reports rspOk=1.
- R9: Opcode 2 (write bit) presents cmdData[0] during one SCL high phase. Opcode 3 (read bit) returns the SDA value sampled while SCL is high as rspData={7'b0, bit}. Both report rspOk=1.
- R10: cmdReady is 1 only while idle and is never 1 together with rspValid. A response stays valid and unchanged until rspReady is taken.
- R11: Opcodes 6 and 7 are reserved. They return rspOk=0 at once and leave both lines as they were.
- R12: Neither line drive changes while the engine is idle or holding a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, accepts a command |
| cmdOp | input | 3 | Opcode: 0 start, 1 stop, 2 write bit, 3 read bit, 4 write byte, 5 read byte |
| cmdData | input | 8 | Byte to write; bit 0 for write bit |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Result taken |
| rspOk | output | 1 | 1 success, 0 timeout/NACK/reserved |
| rspData | output | 8 | Read data or sampled acknowledge |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check the command and response handshake rules on every cycle. They also check that both line drives stay still whenever the engine is idle or holding a result. The line sequences need the bench's bus scenarios. These are the start and stop edges, the conditional recovery start, MSB-first bit order, the acknowledge and NACK handling, and the difference between a stretch that finishes and one that times out. The bench shows them with a wired-AND bus model, a clock-stretching slave and a slave that drives SDA.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_STOP  = 3'd1;
  localparam logic [2:0] OP_WBIT  = 3'd2;
  localparam logic [2:0] OP_RBIT  = 3'd3;
  localparam logic [2:0] OP_WBYTE = 3'd4;
  localparam logic [2:0] OP_RBYTE = 3'd5;

  typedef enum logic [1:0] {SH_KEEP, SH_LOAD, SH_BIT, SH_CLR} shsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   sclSet;
    logic   sclLow;
    logic   sdaSet;
    logic   sdaLow;
    logic   sdaFromShift;
    logic   tmrLoad;
    logic   tmrHold;
    logic   stepLoad;
    logic   stepDec;
    shsel_e shSel;
    logic   shIn;
    logic   shOut;
    logic   bitsLoad;
    logic   bitsByte;
    logic   bitsDec;
  } strobe_t;
endpackage

// File: rtl/i2c_eng_dp.sv
module i2c_eng_dp
  import i2c_eng_pkg::*;
#(
  parameter int RISE_CYC = 250,
  parameter int HOLD_CYC = 1250,
  parameter int STEPS    = 2200
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [7:0] cmdData,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  output logic       tmrZero,
  output logic       stepLast,
  output logic       bitsLast,
  output logic [7:0] shData
);
  localparam int MaxCyc = (RISE_CYC > HOLD_CYC) ? RISE_CYC : HOLD_CYC;
  localparam int TW = $clog2(MaxCyc + 1);
  localparam int SW = $clog2(STEPS + 1);

  logic [TW-1:0] tmr;
  logic [SW-1:0] stepCnt;
  logic [3:0]    bitsLeft;
  logic [7:0]    sh;
  logic          sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr      <= '0;
      stepCnt  <= '0;
      bitsLeft <= '0;
      sh       <= '0;
      sclQ     <= 1'b0;
      sdaQ     <= 1'b0;
    end else begin
      if (stb.tmrLoad)   tmr <= stb.tmrHold ? TW'(HOLD_CYC) : TW'(RISE_CYC);
      else if (tmr != 0) tmr <= tmr - 1'b1;

      if (stb.stepLoad)     stepCnt <= SW'(STEPS);
      else if (stb.stepDec) stepCnt <= stepCnt - 1'b1;

      if (stb.bitsLoad)     bitsLeft <= stb.bitsByte ? 4'd9 : 4'd1;
      else if (stb.bitsDec) bitsLeft <= bitsLeft - 1'b1;

      unique case (stb.shSel)
        SH_LOAD: sh <= cmdData;
        SH_BIT:  sh <= {cmdData[0], 7'b0};
        SH_CLR:  sh <= '0;
        default: begin
          if (stb.shIn)       sh <= {sh[6:0], sdaIn};
          else if (stb.shOut) sh <= {sh[6:0], 1'b0};
        end
      endcase

      if (stb.sclSet) sclQ <= stb.sclLow;
      if (stb.sdaSet) sdaQ <= stb.sdaFromShift ? ~sh[7] : stb.sdaLow;
    end
  end

  assign tmrZero   = (tmr == 0);
  assign stepLast  = (stepCnt == SW'(1));
  assign bitsLast  = (bitsLeft == 4'd1);
  assign shData    = sh;
  assign sclDrvLow = sclQ;
  assign sdaDrvLow = sdaQ;
endmodule

// File: rtl/i2c_eng_ctrl.sv
module i2c_eng_ctrl
  import i2c_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output logic       cmdReady,
  output logic       rspValid,
  input  logic       rspReady,
  output logic       rspOk,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       tmrZero,
  input  logic       stepLast,
  input  logic       bitsLast,
  output strobe_t    stb
);
  typedef enum logic [3:0] {
    S_IDLE, S_BEGIN, S_REC, S_RAISE, S_ST_SDA, S_ST_SCL,
    S_SP_A, S_SP_B, S_SP_C, S_B_SET, S_B_HI, S_B_LO, S_B_NEXT, S_RESP
  } state_e;

  state_e     state, nState;
  logic [2:0] opQ;
  logic       okQ, ackQ, finish, finOk, rdBit, fromShift;

  always_comb begin
    rdBit     = (opQ == OP_RBIT) || (opQ == OP_WBYTE && bitsLast) ||
                (opQ == OP_RBYTE && !bitsLast);
    fromShift = (opQ == OP_WBIT) || (opQ == OP_WBYTE && !bitsLast);
    stb    = '0;
    nState = state;
    finish = 1'b0;
    finOk  = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        nState       = S_BEGIN;
        stb.bitsLoad = 1'b1;
        stb.bitsByte = (cmdOp == OP_WBYTE) || (cmdOp == OP_RBYTE);
        if (cmdOp == OP_WBIT)       stb.shSel = SH_BIT;
        else if (cmdOp == OP_WBYTE) stb.shSel = SH_LOAD;
        else                        stb.shSel = SH_CLR;
      end
      S_BEGIN: begin
        if (opQ == OP_START) begin
          if (sclIn && sdaIn) begin
            stb.sdaSet = 1'b1; stb.sdaLow = 1'b1;
            stb.tmrLoad = 1'b1; stb.tmrHold = 1'b1;
            nState = S_ST_SDA;
          end else begin
            stb.sclSet = 1'b1; stb.sclLow = 1'b1;
            stb.sdaSet = 1'b1; stb.tmrLoad = 1'b1;
            nState = S_REC;
          end
        end else if (opQ == OP_STOP) begin
          stb.sclSet = 1'b1; stb.sclLow = 1'b1;
          stb.sdaSet = 1'b1; stb.sdaLow = 1'b1;
          stb.tmrLoad = 1'b1;
          nState = S_SP_A;
        end else if (opQ <= OP_RBYTE) begin
          stb.sdaSet = 1'b1; stb.sdaFromShift = fromShift;
          stb.tmrLoad = 1'b1;
          nState = S_B_SET;
        end else begin
          finish = 1'b1;
        end
      end
      S_B_NEXT: begin
        stb.sdaSet = 1'b1; stb.sdaFromShift = fromShift;
        stb.tmrLoad = 1'b1;
        nState = S_B_SET;
      end
      S_REC, S_B_SET: if (tmrZero) begin
        stb.sclSet = 1'b1; stb.tmrLoad = 1'b1; stb.stepLoad = 1'b1;
        nState = S_RAISE;
      end
      S_RAISE: if (tmrZero) begin
        if (sclIn) begin
          stb.tmrLoad = 1'b1; stb.tmrHold = 1'b1;
          if (opQ == OP_START) begin
            stb.sdaSet = 1'b1; stb.sdaLow = 1'b1;
            nState = S_ST_SDA;
          end else if (rdBit) begin
            stb.shIn = 1'b1;
            stb.sclSet = 1'b1; stb.sclLow = 1'b1;
            nState = S_B_LO;
          end else begin
            nState = S_B_HI;
          end
        end else if (stepLast) begin
          finish = 1'b1;
        end else begin
          stb.stepDec = 1'b1; stb.tmrLoad = 1'b1;
        end
      end
      S_ST_SDA, S_B_HI: if (tmrZero) begin
        stb.sclSet = 1'b1; stb.sclLow = 1'b1;
        stb.tmrLoad = 1'b1; stb.tmrHold = 1'b1;
        nState = (state == S_ST_SDA) ? S_ST_SCL : S_B_LO;
      end
      S_B_LO: if (tmrZero) begin
        stb.shOut   = fromShift;
        stb.bitsDec = 1'b1;
        if (bitsLast) begin
          finish = 1'b1;
          finOk  = !(opQ == OP_WBYTE && ackQ);
        end else begin
          nState = S_B_NEXT;
        end
      end
      S_SP_A: if (tmrZero) begin
        stb.sclSet = 1'b1; stb.tmrLoad = 1'b1; stb.tmrHold = 1'b1;
        nState = S_SP_B;
      end
      S_SP_B: if (tmrZero) begin
        stb.sdaSet = 1'b1; stb.tmrLoad = 1'b1; stb.tmrHold = 1'b1;
        nState = S_SP_C;
      end
      S_ST_SCL, S_SP_C: if (tmrZero) begin
        finish = 1'b1;
        finOk  = 1'b1;
      end
      S_RESP: if (rspReady) nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
    if (finish) nState = S_RESP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= '0;
      okQ   <= 1'b0;
      ackQ  <= 1'b0;
    end else begin
      state <= nState;
      if (state == S_IDLE && cmdValid) opQ <= cmdOp;
      if (finish) okQ <= finOk;
      if (stb.shIn) ackQ <= sdaIn;
    end
  end

  assign cmdReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign rspOk    = okQ;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_eng_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int RISE_NS    = 1000,
  parameter int HOLD_NS    = 5000,
  parameter int TIMEOUT_NS = 2200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic [2:0] cmdOp,
  input  logic [7:0] cmdData,
  output logic       rspValid,
  input  logic       rspReady,
  output logic       rspOk,
  output logic [7:0] rspData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclDrvLow,
  output logic       sdaDrvLow
);
  localparam int RiseCyc = (RISE_NS * CLK_MHZ + 999) / 1000;
  localparam int HoldCyc = (HOLD_NS * CLK_MHZ + 999) / 1000;
  localparam int Steps   = TIMEOUT_NS / RISE_NS;

  strobe_t stb;
  logic    tmrZero, stepLast, bitsLast;

  i2c_eng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdReady(cmdReady), .rspValid(rspValid), .rspReady(rspReady),
    .rspOk(rspOk), .sclIn(sclIn), .sdaIn(sdaIn), .tmrZero(tmrZero),
    .stepLast(stepLast), .bitsLast(bitsLast), .stb(stb)
  );

  i2c_eng_dp #(.RISE_CYC(RiseCyc), .HOLD_CYC(HoldCyc), .STEPS(Steps)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdData(cmdData), .sdaIn(sdaIn),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .tmrZero(tmrZero),
    .stepLast(stepLast), .bitsLast(bitsLast), .shData(rspData)
  );
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic       rspValid,
  input logic       rspReady,
  input logic       rspOk,
  input logic [7:0] rspData,
  input logic       sclDrvLow,
  input logic       sdaDrvLow
);
  // R10: a pending response is held unchanged
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspOk) && $stable(rspData));

  // R10: never ready while a response is pending
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && rspValid));

  // R10: an accepted command makes the engine busy
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);

  // R12: lines quiet while idle or holding a response
  a_r12_lines_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady || rspValid) |=> $stable(sclDrvLow) && $stable(sdaDrvLow));
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .rspValid(rspValid), .rspReady(rspReady), .rspOk(rspOk),
  .rspData(rspData), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
);

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, rspReady = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] cmdData = '0;
  logic cmdReady, rspValid, rspOk, sclDrvLow, sdaDrvLow, sclIn, sdaIn;
  logic [7:0] rspData;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bus and slave model
  int   stretchCyc = 0, relCnt = 0, falls = 0, fallBase = 0, starts = 0, stops = 0;
  logic txMode = 1'b0, ackMode = 1'b0;
  logic [7:0] txByte = '0;
  logic [8:0] monBits = '0;
  logic prevScl = 1'b1, prevSda = 1'b1, slaveSclLow, slaveSdaLow;

  always #2 clk = ~clk;

  i2c_bit_engine #(.CLK_MHZ(250), .RISE_NS(20), .HOLD_NS(40), .TIMEOUT_NS(200)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .rspValid(rspValid), .rspReady(rspReady),
    .rspOk(rspOk), .rspData(rspData), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  always_comb begin
    int idx;
    idx = falls - fallBase;
    slaveSclLow = (relCnt < stretchCyc);
    slaveSdaLow = (txMode && idx >= 0 && idx < 8 && !txByte[7 - idx]) ||
                  (ackMode && idx == 8);
  end
  assign sclIn = !sclDrvLow && !slaveSclLow;
  assign sdaIn = !sdaDrvLow && !slaveSdaLow;

  always @(posedge clk) begin
    prevScl <= sclIn;
    prevSda <= sdaIn;
    if (sclDrvLow) relCnt <= 0; else if (relCnt < 1000000) relCnt <= relCnt + 1;
    if (!prevScl && sclIn) monBits <= {monBits[7:0], sdaIn};
    if (prevScl && !sclIn) falls <= falls + 1;
    if (prevScl && sclIn && prevSda && !sdaIn) starts <= starts + 1;
    if (prevScl && sclIn && !prevSda && sdaIn) stops <= stops + 1;
  end

  function automatic logic expWrOk(input logic slaveAcks);
    return slaveAcks;
  endfunction
  function automatic logic [7:0] expWrData(input logic slaveAcks);
    return {7'b0, !slaveAcks};
  endfunction

  task automatic check(input bit cond, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [7:0] d,
                        output logic ok, output logic [7:0] rd);
    @(negedge clk);
    fallBase = falls;
    cmdOp = op; cmdData = d; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check(!cmdReady, "R10 busy after accept", cmdReady, 0);
    while (!rspValid) @(negedge clk);
    ok = rspOk; rd = rspData;
    repeat (2) @(negedge clk);
    check(rspValid && rspOk == ok && rspData == rd, "R10 response held", rspValid, 1);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check(!rspValid && cmdReady, "R10 released to idle", cmdReady, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [7:0] rd;
    int s0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check(cmdReady && !rspValid && !sclDrvLow && !sdaDrvLow, "R1 reset state", cmdReady, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cmdReady && !rspValid && !sclDrvLow && !sdaDrvLow, "R1 after reset", sclDrvLow, 0);

    // R2 plain start
    s0 = starts;
    runCmd(3'd0, 8'h00, ok, rd);
    check(ok && starts == s0 + 1 && sclDrvLow && sdaDrvLow, "R2 plain start", starts - s0, 1);

    // R7 write byte with ACK
    ackMode = 1'b1;
    runCmd(3'd4, 8'hA5, ok, rd);
    check(ok == expWrOk(1'b1), "R7 ack ok", ok, 1);
    check(monBits[8:1] == 8'hA5 && rd == expWrData(1'b1), "R7 bits msb first", monBits[8:1], 8'hA5);
    // R7 write byte with NACK
    ackMode = 1'b0;
    runCmd(3'd4, 8'h3C, ok, rd);
    check(ok == expWrOk(1'b0) && rd == expWrData(1'b0), "R7 nack", {ok, rd}, {1'b0, 8'h01});

    // R8 read byte
    txMode = 1'b1; txByte = 8'h96;
    runCmd(3'd5, 8'h00, ok, rd);
    txMode = 1'b0;
    check(ok && rd == 8'h96, "R8 read data", rd, 8'h96);
    check(monBits[0] == 1'b1, "R8 nack bit released", monBits[0], 1);

    // R9 single bits
    runCmd(3'd2, 8'h01, ok, rd);
    check(ok && monBits[0] == 1'b1, "R9 write bit 1", monBits[0], 1);
    runCmd(3'd2, 8'hFE, ok, rd);
    check(ok && monBits[0] == 1'b0, "R9 write bit 0", monBits[0], 0);
    txMode = 1'b1; txByte = 8'h00;
    runCmd(3'd3, 8'h00, ok, rd);
    check(ok && rd == 8'h00, "R9 read bit 0", rd, 0);
    txByte = 8'hFF;
    runCmd(3'd3, 8'h00, ok, rd);
    txMode = 1'b0;
    check(ok && rd == 8'h01, "R9 read bit 1", rd, 1);

    // R3 repeated start from SCL low
    runCmd(3'd2, 8'h00, ok, rd);
    s0 = starts;
    runCmd(3'd0, 8'h00, ok, rd);
    check(ok && starts == s0 + 1, "R3 recovery start", starts - s0, 1);

    // R5 short stretch
    stretchCyc = 23;
    runCmd(3'd2, 8'h01, ok, rd);
    check(ok == 1'b1 && monBits[0], "R5 stretch tolerated", ok, 1);
    // R4 timeout
    stretchCyc = 1000000;
    runCmd(3'd2, 8'h01, ok, rd);
    check(ok == 1'b0 && !sclDrvLow, "R4 timeout fails", {ok, sclDrvLow}, 0);
    stretchCyc = 0;

    // R11 reserved opcode, lines untouched
    begin
      logic scl0, sda0;
      scl0 = sclDrvLow; sda0 = sdaDrvLow;
      runCmd(3'd7, 8'h00, ok, rd);
      check(!ok && sclDrvLow == scl0 && sdaDrvLow == sda0, "R11 reserved op 7", ok, 0);
      runCmd(3'd6, 8'h00, ok, rd);
      check(!ok && sclDrvLow == scl0 && sdaDrvLow == sda0, "R11 reserved op 6", ok, 0);
    end

    // R6 stop
    s0 = stops;
    runCmd(3'd1, 8'h00, ok, rd);
    check(ok && stops == s0 + 1 && !sclDrvLow && !sdaDrvLow, "R6 stop", stops - s0, 1);

    // random transactions
    for (int i = 0; i < 24; i++) begin
      logic [7:0] v;
      logic acks, isWr;
      v = 8'($urandom); acks = 1'($urandom); isWr = 1'($urandom);
      s0 = starts;
      runCmd(3'd0, 8'h00, ok, rd);
      check(ok && starts == s0 + 1, "R2 random start", starts - s0, 1);
      if (isWr) begin
        ackMode = acks;
        runCmd(3'd4, v, ok, rd);
        ackMode = 1'b0;
        check(ok == expWrOk(acks) && monBits[8:1] == v && rd == expWrData(acks),
              "R7 random write", monBits[8:1], v);
      end else begin
        txMode = 1'b1; txByte = v;
        runCmd(3'd5, 8'h00, ok, rd);
        txMode = 1'b0;
        check(ok && rd == v && monBits[0], "R8 random read", rd, v);
      end
      s0 = stops;
      runCmd(3'd1, 8'h00, ok, rd);
      check(ok && stops == s0 + 1, "R6 random stop", stops - s0, 1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule